// File: doc/BRIEF.md
# USB 2.0 Host Controller Command and Status Registers

This block holds the software-visible command and status words of a USB 2.0 host controller, together with an interrupt-enable mask. Software reaches all three words through a plain memory-mapped register port: a one-cycle write strobe, or a one-cycle read strobe whose data comes back on the following cycle. The register port is not a data stream. It has no ready signal, and it accepts one access on every cycle.

Software writes the command word to start or stop the controller, to enable the asynchronous and periodic schedules, and to arm the async-advance doorbell. A separate schedule engine outside this block reports its real condition through strobes and levels: schedule transition complete, async schedule advanced, engine stopped, async list empty, and internal error. The status word shows what the engine has actually done, not what software last asked for. The status bit for each schedule follows its enable only when the engine confirms the change. The halted flag follows the engine's stop. The async-advance event is latched as a write-1-to-clear flag. When its mask bit is set, that flag drives the interrupt output.

Word addresses: 0 is the command word, 1 is the status word, 2 is the mask word. Any other address reads as zero and ignores writes.

Top module: `hc_status_regs`

## Requirements
- R1: After reset the status word reads 0x00001000, and the command word and the mask word both read 0. The interrupt output is low.
- R2: Status bits 31:16 and 11:6 always read 0. Writing ones to them changes nothing that can be read back.
- R3: Status bit 15 (async schedule active) takes the value of command bit 5 (async enable) only on a cycle where `sch_async_done` is high. It holds its value on every other cycle.
- R4: Status bit 14 (periodic schedule active) takes the value of command bit 4 (periodic enable) only on a cycle where `sch_periodic_done` is high. It holds its value on every other cycle.
- R5: Status bit 13 (list empty) shows the value that `sch_reclaim` had on the previous cycle. It is 0 after reset.
- R6: Status bit 12 (halted) reads 0 whenever command bit 0 (run) is 1. After run returns to 0, bit 12 becomes 1 only on the cycle after `sch_stopped` has been seen high.
- R7: A pulse on `hc_internal_err` clears command bit 0. This takes priority over a software write of 1 to that bit in the same cycle.
- R8: Writing 1 to command bit 6 arms the doorbell, and bit 6 reads back as 1 while it is armed. A `sch_async_advance` pulse seen while the doorbell is armed sets status bit 5 and clears bit 6 at the same clock edge. An advance pulse seen while the doorbell is not armed changes nothing.
- R9: Status bit 5 is write-1-to-clear. Writing 0 to it leaves it unchanged. If hardware sets the bit in the same cycle that software clears it, the set wins.
- R10: `irq` is high exactly when status bit 5 is 1 and mask bit 5 is 1.
- R11: A read strobe returns `reg_rd_valid` high with the addressed word on the next cycle. `reg_rd_valid` is low on every other cycle.
- R12: Writes to status bits 15:12 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_rd_en | input | 1 | Read strobe |
| reg_wr_en | input | 1 | Write strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rd_valid | output | 1 | Read data valid, one cycle after the strobe |
| reg_rd_data | output | DATA_W | Read data |
| sch_async_done | input | 1 | Engine has finished switching the async schedule |
| sch_periodic_done | input | 1 | Engine has finished switching the periodic schedule |
| sch_async_advance | input | 1 | Engine has advanced the async schedule |
| sch_stopped | input | 1 | Engine is stopped |
| sch_reclaim | input | 1 | Engine's async-list-empty flag |
| hc_internal_err | input | 1 | Engine internal error; forces a stop |
| irq | output | 1 | Masked interrupt request |

## Verification
Every piece of internal state in this block shows at the ports within two cycles. A wrong doorbell or a wrong advance flag shows on `irq` on the next cycle once the mask bit is set. A wrong run, schedule-status, halted or list-empty bit shows on the cycle after any read of its word. For this reason the bench checks `irq` and `reg_rd_valid` on every clock against a behavioural model, and it issues reads often. The hard cases are ordering conflicts at a single clock edge: an error against a run write, a hardware set against a software clear, and an advance pulse with no armed doorbell. Each of these is driven and then read back directly.

// File: rtl/hc_regs_pkg.sv
package hc_regs_pkg;
  // command word bit positions
  localparam int unsigned CMD_RUN   = 0;
  localparam int unsigned CMD_PEREN = 4;
  localparam int unsigned CMD_ASYEN = 5;
  localparam int unsigned CMD_BELL  = 6;
  // status word bit positions
  localparam int unsigned STS_ADV   = 5;
  localparam int unsigned STS_HALT  = 12;
  localparam int unsigned STS_RECL  = 13;
  localparam int unsigned STS_PER   = 14;
  localparam int unsigned STS_ASY   = 15;
  // mask word bit position
  localparam int unsigned MSK_ADV   = 5;
  // word addresses
  localparam int unsigned A_CMD  = 0;
  localparam int unsigned A_STS  = 1;
  localparam int unsigned A_MASK = 2;
endpackage

// File: rtl/hc_cmd_reg.sv
module hc_cmd_reg
  import hc_regs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fatal,
  input  logic              advance,
  output logic              run,
  output logic              per_en,
  output logic              asy_en,
  output logic              bell,
  output logic              adv_fire
);
  assign adv_fire = bell & advance;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      per_en <= 1'b0;
      asy_en <= 1'b0;
      bell   <= 1'b0;
    end else begin
      if (fatal)   run <= 1'b0;
      else if (wr) run <= wdata[CMD_RUN];
      if (wr) begin
        per_en <= wdata[CMD_PEREN];
        asy_en <= wdata[CMD_ASYEN];
      end
      bell <= (bell & ~adv_fire) | (wr & wdata[CMD_BELL]);
    end
  end

  // R7: an internal error always leaves run cleared
  a_r7_fatal_stops: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> !run);
  // R8: a fired doorbell is disarmed unless software re-arms it at once
  a_r8_bell_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_fire && !(wr && wdata[CMD_BELL])) |=> !bell);
  // R8: an advance pulse alone never arms the doorbell
  a_r8_no_self_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (!bell && !wr) |=> !bell);
endmodule

// File: rtl/hc_sched_track.sv
module hc_sched_track (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic per_en,
  input  logic asy_en,
  input  logic asy_done,
  input  logic per_done,
  input  logic stopped,
  input  logic reclaim,
  output logic asy_sts,
  output logic per_sts,
  output logic halted,
  output logic recl
);
  logic halt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asy_sts <= 1'b0;
      per_sts <= 1'b0;
      halt_q  <= 1'b1;
      recl    <= 1'b0;
    end else begin
      if (asy_done) asy_sts <= asy_en;
      if (per_done) per_sts <= per_en;
      if (run)          halt_q <= 1'b0;
      else if (stopped) halt_q <= 1'b1;
      recl <= reclaim;
    end
  end

  assign halted = halt_q & ~run;

  // R3: async status moves only on the engine's confirmation
  a_r3_async_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !asy_done |=> $stable(asy_sts));
  // R4: periodic status copies the enable seen on the done cycle
  a_r4_per_copy: assert property (@(posedge clk) disable iff (!rst_n)
    per_done |=> (per_sts == $past(per_en)));
  // R6: halted can only rise after the engine reported a stop
  a_r6_halt_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(stopped));
endmodule

// File: rtl/hc_irq_w1c.sv
module hc_irq_w1c (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sts_wr,
  input  logic clr_bit,
  input  logic mask_wr,
  input  logic mask_bit,
  output logic adv_sts,
  output logic mask,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adv_sts <= 1'b0;
      mask    <= 1'b0;
    end else begin
      if (hw_set)                  adv_sts <= 1'b1;
      else if (sts_wr && clr_bit)  adv_sts <= 1'b0;
      if (mask_wr) mask <= mask_bit;
    end
  end

  assign irq = adv_sts & mask;

  // R9: hardware set wins over a same-cycle clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> adv_sts);
  // R9: a zero write never clears the flag
  a_r9_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_sts && !(sts_wr && clr_bit)) |=> adv_sts);
endmodule

// File: rtl/hc_status_regs.sv
module hc_status_regs
  import hc_regs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd_en,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rd_valid,
  output logic [DATA_W-1:0] reg_rd_data,
  input  logic              sch_async_done,
  input  logic              sch_periodic_done,
  input  logic              sch_async_advance,
  input  logic              sch_stopped,
  input  logic              sch_reclaim,
  input  logic              hc_internal_err,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] AD_CMD  = ADDR_W'(A_CMD);
  localparam logic [ADDR_W-1:0] AD_STS  = ADDR_W'(A_STS);
  localparam logic [ADDR_W-1:0] AD_MASK = ADDR_W'(A_MASK);

  logic wr_cmd, wr_sts, wr_mask;
  logic run, per_en, asy_en, bell, adv_fire;
  logic asy_sts, per_sts, halted, recl;
  logic adv_sts, mask;
  logic [DATA_W-1:0] cmd_word, sts_word, mask_word, rd_mux;

  assign wr_cmd  = reg_wr_en && (reg_addr == AD_CMD);
  assign wr_sts  = reg_wr_en && (reg_addr == AD_STS);
  assign wr_mask = reg_wr_en && (reg_addr == AD_MASK);

  hc_cmd_reg #(.DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr(wr_cmd), .wdata(reg_wdata),
    .fatal(hc_internal_err), .advance(sch_async_advance),
    .run(run), .per_en(per_en), .asy_en(asy_en), .bell(bell),
    .adv_fire(adv_fire));

  hc_sched_track u_track (
    .clk(clk), .rst_n(rst_n), .run(run), .per_en(per_en), .asy_en(asy_en),
    .asy_done(sch_async_done), .per_done(sch_periodic_done),
    .stopped(sch_stopped), .reclaim(sch_reclaim),
    .asy_sts(asy_sts), .per_sts(per_sts), .halted(halted), .recl(recl));

  hc_irq_w1c u_irq (
    .clk(clk), .rst_n(rst_n), .hw_set(adv_fire), .sts_wr(wr_sts),
    .clr_bit(reg_wdata[STS_ADV]), .mask_wr(wr_mask),
    .mask_bit(reg_wdata[MSK_ADV]), .adv_sts(adv_sts), .mask(mask),
    .irq(irq));

  always_comb begin
    cmd_word = '0;
    cmd_word[CMD_RUN]   = run;
    cmd_word[CMD_PEREN] = per_en;
    cmd_word[CMD_ASYEN] = asy_en;
    cmd_word[CMD_BELL]  = bell;
    sts_word = '0;
    sts_word[STS_ADV]  = adv_sts;
    sts_word[STS_HALT] = halted;
    sts_word[STS_RECL] = recl;
    sts_word[STS_PER]  = per_sts;
    sts_word[STS_ASY]  = asy_sts;
    mask_word = '0;
    mask_word[MSK_ADV] = mask;
    unique case (reg_addr)
      AD_CMD:  rd_mux = cmd_word;
      AD_STS:  rd_mux = sts_word;
      AD_MASK: rd_mux = mask_word;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rd_valid <= 1'b0;
      reg_rd_data  <= '0;
    end else begin
      reg_rd_valid <= reg_rd_en;
      if (reg_rd_en) reg_rd_data <= rd_mux;
    end
  end

  // R11: one-cycle read response, none without a request
  a_r11_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> reg_rd_valid);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> !reg_rd_valid);
  // R2: reserved status bits never appear on a status read
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && reg_addr == AD_STS) |=>
      (reg_rd_data[DATA_W-1:16] == '0 && reg_rd_data[11:6] == '0));
endmodule

// File: tb/hc_status_regs_bench.sv
`timescale 1ns/1ps
module hc_status_regs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic rd_valid, irq;
  logic [31:0] rd_data;
  logic a_done = 0, p_done = 0, adv = 0, stopped = 0, reclaim = 0, fatal = 0;

  always #2 clk = ~clk;

  hc_status_regs u_hc_status_regs (
    .clk(clk), .rst_n(rst_n), .reg_rd_en(rd_en), .reg_wr_en(wr_en),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rd_valid(rd_valid),
    .reg_rd_data(rd_data), .sch_async_done(a_done),
    .sch_periodic_done(p_done), .sch_async_advance(adv),
    .sch_stopped(stopped), .sch_reclaim(reclaim),
    .hc_internal_err(fatal), .irq(irq));

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_run, m_pen, m_aen, m_bell, m_as, m_ps, m_halt, m_recl, m_adv, m_mask;
  bit e_valid;
  logic [31:0] e_data;

  function automatic logic [31:0] model_word(input logic [1:0] a);
    logic [31:0] w = 0;
    case (a)
      2'd0: begin w[0] = m_run; w[4] = m_pen; w[5] = m_aen; w[6] = m_bell; end
      2'd1: begin w[5] = m_adv; w[12] = m_halt & ~m_run; w[13] = m_recl;
                  w[14] = m_ps; w[15] = m_as; end
      2'd2: w[5] = m_mask;
      default: w = 0;
    endcase
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_run, m_pen, m_aen, m_bell, m_as, m_ps, m_recl, m_adv, m_mask} = '0;
      m_halt = 1; e_valid = 0; e_data = 0;
    end else begin
      bit fire;
      fire = m_bell && adv;
      e_valid = rd_en;
      if (rd_en) e_data = model_word(addr);
      if (m_run) m_halt = 0; else if (stopped) m_halt = 1;
      if (a_done) m_as = m_aen;
      if (p_done) m_ps = m_pen;
      m_recl = reclaim;
      if (fire) m_adv = 1;
      else if (wr_en && addr == 2'd1 && wdata[5]) m_adv = 0;
      if (wr_en && addr == 2'd2) m_mask = wdata[5];
      m_bell = (m_bell && !fire) || (wr_en && addr == 2'd0 && wdata[6]);
      if (fatal) m_run = 0; else if (wr_en && addr == 2'd0) m_run = wdata[0];
      if (wr_en && addr == 2'd0) begin m_pen = wdata[4]; m_aen = wdata[5]; end
    end
  end

  // per-clock comparison against the model (R10, R11)
  always @(negedge clk) if (rst_n && !finished) begin
    chk(rd_valid == e_valid, "R11 model valid", 32'(rd_valid), 32'(e_valid));
    if (e_valid) chk(rd_data == e_data, "R11 model data", rd_data, e_data);
    chk(irq == (m_adv & m_mask), "R10 model irq", 32'(irq), 32'(m_adv & m_mask));
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    chk(rd_valid && rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic summary();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(irq == 0, "R1 irq after reset", 32'(irq), 0);
    rd(2'd1, 32'h0000_1000, "R1 status reset");
    rd(2'd0, 32'h0, "R1 command reset");
    rd(2'd2, 32'h0, "R1 mask reset");
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, 32'h0000_1000, "R2 R12 reserved and RO ignored");
    wr(2'd0, 32'h31);
    rd(2'd1, 32'h0, "R6 halted low while running, R3 R4 lag");
    pulse(a_done);
    rd(2'd1, 32'h8000, "R3 async status after done");
    pulse(p_done);
    rd(2'd1, 32'hC000, "R4 periodic status after done");
    @(negedge clk); reclaim = 1;
    rd(2'd1, 32'hE000, "R5 list empty reflected");
    @(negedge clk); reclaim = 0;
    @(negedge clk);
    rd(2'd1, 32'hC000, "R5 list empty cleared");
    pulse(adv);
    rd(2'd1, 32'hC000, "R8 unarmed advance ignored");
    wr(2'd0, 32'h71);
    rd(2'd0, 32'h71, "R8 doorbell armed");
    pulse(adv);
    rd(2'd0, 32'h31, "R8 doorbell self-cleared");
    rd(2'd1, 32'hC020, "R8 advance flag set");
    chk(irq == 0, "R10 masked irq low", 32'(irq), 0);
    wr(2'd2, 32'h20);
    chk(irq == 1, "R10 irq with mask", 32'(irq), 1);
    wr(2'd1, 32'h0);
    rd(2'd1, 32'hC020, "R9 zero write keeps flag");
    wr(2'd1, 32'h20);
    rd(2'd1, 32'hC000, "R9 one write clears flag");
    chk(irq == 0, "R10 irq after clear", 32'(irq), 0);
    wr(2'd0, 32'h71);
    @(negedge clk); adv = 1; wr_en = 1; addr = 2'd1; wdata = 32'h20;
    @(negedge clk); adv = 0; wr_en = 0;
    rd(2'd1, 32'hC020, "R9 hardware set beats clear");
    wr(2'd1, 32'h20);
    wr(2'd0, 32'h30);
    rd(2'd1, 32'hC000, "R6 not halted before engine stop");
    @(negedge clk); stopped = 1;
    @(negedge clk);
    rd(2'd1, 32'hD000, "R6 halted after engine stop");
    wr(2'd0, 32'h31);
    stopped = 0;
    @(negedge clk); fatal = 1; wr_en = 1; addr = 2'd0; wdata = 32'h31;
    @(negedge clk); fatal = 0; wr_en = 0;
    rd(2'd0, 32'h30, "R7 error beats run write");
    rd(2'd3, 32'h0, "R11 unmapped address reads zero");
    repeat (4) @(negedge clk);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      summary();
    end
  end
endmodule